// File: doc/BRIEF.md
# Serial DAC command receiver

This block is the digital front end of a single-channel digital-to-analog converter that is programmed over a three-wire serial link. A fast system clock samples the serial clock, the serial data input and an active-low chip-select/load line through two-flop synchronisers. While the select line is low, each rising serial-clock edge shifts one data bit into a 32-bit shift register. The oldest bit of that register is driven on a serial data output, so several receivers can be chained by linking the output of one to the data input of the next.

When the select line rises, the frame is closed. The last 24 bits shifted in are decoded as a 4-bit command, four ignored bits and a 16-bit data field. The data field carries a code of `RES` bits (12, 14 or 16) aligned to its most significant end. For each supported command the block emits a one-cycle strobe, together with a valid flag, the command value and the code. Frames that are too short and reserved commands produce nothing. The serial clock must run slower than a quarter of the system clock.

Top module: `dac_serial_rx`

## Requirements
- R1: After reset `sdo_o` is 0, and `cmd_vld_o` and all five strobes are 0 until a frame is decoded.
- R2: A data bit is captured only on a rising serial-clock edge that is seen while chip-select/load is low. Clock edges while the select is high change neither the shift register nor `sdo_o`.
- R3: The shift register holds 32 bits. A frame may carry 24 or 32 bits, and only the last 24 bits shifted in are decoded. The first 8 bits of a 32-bit frame are ignored padding.
- R4: In the decoded 24 bits, the first four bits sent form the command (most significant bit first). The next four bits are ignored. The final sixteen form the data field, most significant bit first. `cmd_code_o` is the top `RES` bits of the data field, and the lowest 16−`RES` bits are ignored.
- R5: On every falling serial-clock edge seen while the select is low, `sdo_o` takes the most significant bit of the shift register. That bit is the one captured 32 accepted rising edges earlier, counting the latest edge.
- R6: The rising edge of chip-select/load closes the frame. A frame with fewer than 24 accepted rising edges produces no valid and no strobe.
- R7: On a decoded frame the commands map to strobes as follows: 4'b0000 gives `stb_write_o`, 4'b0001 gives `stb_update_o`, 4'b0011 gives `stb_wr_upd_o`, 4'b0100 gives `stb_pwr_dn_o` and 4'b1111 gives `stb_nop_o`. Exactly one strobe is raised.
- R8: Any other command value produces no valid and no strobe, the same as a discarded frame.
- R9: Each decoded frame raises `cmd_vld_o` for exactly one system clock cycle, carrying the command and code. Outside that cycle `cmd_op_o` and `cmd_code_o` are zero.
- R10: A rising serial-clock edge that is synchronised in the same cycle as the closing select edge still counts as the last bit of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| csld_n_i | input | 1 | Active-low chip-select; its rising edge loads the frame |
| sdo_o | output | 1 | Serial data out for chaining |
| cmd_vld_o | output | 1 | One-cycle valid for a decoded command |
| cmd_op_o | output | 4 | Decoded command value |
| cmd_code_o | output | RES | Decoded DAC code |
| stb_write_o | output | 1 | Write-input strobe |
| stb_update_o | output | 1 | Update strobe |
| stb_wr_upd_o | output | 1 | Write-and-update strobe |
| stb_pwr_dn_o | output | 1 | Power-down strobe |
| stb_nop_o | output | 1 | No-operation strobe |

## Verification
The closing select edge and the final serial-clock rising edge can be synchronised in the same system cycle. The shift and the frame close then compete for that cycle. The bench provokes this by raising both input lines on the same system-clock edge at the 24th bit of a write frame. The result is judged correct only if a write strobe appears carrying the full code. A dropped edge would leave 23 bits, and the frame would then be discarded without any strobe.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

   localparam int FRAME_BITS = 24;
   localparam int DATA_BITS  = 16;
   localparam int OP_BITS    = 4;
   localparam int OP_LSB     = FRAME_BITS - OP_BITS;

   typedef enum logic [OP_BITS-1:0] {
      OP_WRITE  = 4'b0000,
      OP_UPDATE = 4'b0001,
      OP_WR_UPD = 4'b0011,
      OP_PWR_DN = 4'b0100,
      OP_NOP    = 4'b1111
   } dac_op_e;

   typedef struct packed {
      logic write;
      logic update;
      logic wr_upd;
      logic pwr_dn;
      logic nop;
   } dac_stb_t;

   function automatic dac_stb_t op_strobes(input logic [OP_BITS-1:0] op);
      dac_stb_t s;
      s = '0;
      case (op)
         OP_WRITE:  s.write  = 1'b1;
         OP_UPDATE: s.update = 1'b1;
         OP_WR_UPD: s.wr_upd = 1'b1;
         OP_PWR_DN: s.pwr_dn = 1'b1;
         OP_NOP:    s.nop    = 1'b1;
         default:   s        = '0;
      endcase
      return s;
   endfunction

   function automatic logic op_known(input logic [OP_BITS-1:0] op);
      return |op_strobes(op);
   endfunction

endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dac_rx_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
         else        chain <= {chain[STAGES-1:0], async_i[g]};
      end

      assign sync_o[g] = chain[STAGES-1];
      assign prev_o[g] = chain[STAGES];
   end

endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift #(
   parameter  int SR_LEN   = 32,
   parameter  int OUT_BITS = 24,
   localparam int CNT_W    = $clog2(SR_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                act_i,
   input  logic                rise_i,
   input  logic                fall_i,
   input  logic                sdi_i,
   output logic [OUT_BITS-1:0] word_o,
   output logic [CNT_W-1:0]    cnt_o,
   output logic                sdo_o
);

   if (OUT_BITS > SR_LEN) begin : g_bad_len
      $error("dac_rx_shift: OUT_BITS exceeds SR_LEN");
   end

   logic [SR_LEN-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sr <= '0;
      else if (act_i && rise_i)  sr <= {sr[SR_LEN-2:0], sdi_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_o <= '0;
      else if (!act_i)  cnt_o <= '0;
      else if (rise_i && cnt_o != CNT_W'(SR_LEN))
                        cnt_o <= cnt_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sdo_o <= 1'b0;
      else if (act_i && fall_i)  sdo_o <= sr[SR_LEN-1];
   end

   assign word_o = sr[OUT_BITS-1:0];

   // R2: outside a frame the register does not move
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> $stable(sr));

   // R5: serial output changes only after an accepted falling edge
   assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo_o) |-> $past(act_i && fall_i));

   // R3: edge count saturates at the register length
   assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= CNT_W'(SR_LEN));

endmodule

// File: rtl/dac_rx_decode.sv
module dac_rx_decode
   import dac_rx_pkg::*;
#(
   parameter int RES   = 16,
   parameter int CNT_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  close_i,
   input  logic [CNT_W-1:0]      cnt_i,
   input  logic [FRAME_BITS-1:0] word_i,
   output logic                  vld_o,
   output logic [OP_BITS-1:0]    op_o,
   output logic [RES-1:0]        code_o,
   output dac_stb_t              stb_o
);

   logic [OP_BITS-1:0]   op_w;
   logic [DATA_BITS-1:0] data_w;
   logic [RES-1:0]       code_w;
   logic                 full_w;
   logic                 fire_w;
   logic                 unused_dc;

   assign op_w      = word_i[FRAME_BITS-1 -: OP_BITS];
   assign data_w    = word_i[DATA_BITS-1:0];
   assign code_w    = data_w[DATA_BITS-1 -: RES];
   assign unused_dc = ^word_i[OP_LSB-1:DATA_BITS];
   assign full_w    = cnt_i >= CNT_W'(FRAME_BITS);
   assign fire_w    = close_i && full_w && op_known(op_w);

   if (RES < DATA_BITS) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^data_w[DATA_BITS-RES-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         op_o   <= '0;
         code_o <= '0;
         stb_o  <= '0;
      end else begin
         vld_o  <= fire_w;
         op_o   <= fire_w ? op_w : '0;
         code_o <= fire_w ? code_w : '0;
         stb_o  <= fire_w ? op_strobes(op_w) : '0;
      end
   end

   // R9: valid lasts one cycle
   assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);

   // R7: at most one strobe at a time
   assert_stb_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_o));

   // R8: reserved command is silent
   assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (close_i && !op_known(op_w)) |=> !vld_o);

   // R6: short frame is discarded
   assert_short_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (close_i && cnt_i < CNT_W'(FRAME_BITS)) |=> !vld_o);

endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
   import dac_rx_pkg::*;
#(
   parameter  int RES         = 16,
   parameter  int SR_LEN      = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int CNT_W       = $clog2(SR_LEN + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sck_i,
   input  logic           sdi_i,
   input  logic           csld_n_i,
   output logic           sdo_o,
   output logic           cmd_vld_o,
   output logic [3:0]     cmd_op_o,
   output logic [RES-1:0] cmd_code_o,
   output logic           stb_write_o,
   output logic           stb_update_o,
   output logic           stb_wr_upd_o,
   output logic           stb_pwr_dn_o,
   output logic           stb_nop_o
);

   if (!(RES == 12 || RES == 14 || RES == 16)) begin : g_bad_res
      $error("dac_serial_rx: RES must be 12, 14 or 16");
   end
   if (SR_LEN < FRAME_BITS) begin : g_bad_sr
      $error("dac_serial_rx: SR_LEN shorter than a frame");
   end

   localparam int IDX_SCK = 0;
   localparam int IDX_SDI = 1;
   localparam int IDX_CS  = 2;

   logic [2:0]            in_s;
   logic [2:0]            in_p;
   logic                  frame_act;
   logic                  sck_rise;
   logic                  sck_fall;
   logic                  cs_close;
   logic                  close_q;
   logic                  unused_sdi_prev;
   logic [FRAME_BITS-1:0] word;
   logic [CNT_W-1:0]      cnt;
   dac_stb_t              stb;

   dac_rx_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({csld_n_i, sdi_i, sck_i}),
      .sync_o  (in_s),
      .prev_o  (in_p)
   );

   // a frame stays open through the cycle in which the close is seen
   assign frame_act       = ~in_p[IDX_CS];
   assign sck_rise        = in_s[IDX_SCK] & ~in_p[IDX_SCK];
   assign sck_fall        = ~in_s[IDX_SCK] & in_p[IDX_SCK];
   assign cs_close        = in_s[IDX_CS] & ~in_p[IDX_CS];
   assign unused_sdi_prev = in_p[IDX_SDI];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) close_q <= 1'b0;
      else        close_q <= cs_close;
   end

   dac_rx_shift #(
      .SR_LEN   (SR_LEN),
      .OUT_BITS (FRAME_BITS)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (frame_act),
      .rise_i (sck_rise),
      .fall_i (sck_fall),
      .sdi_i  (in_s[IDX_SDI]),
      .word_o (word),
      .cnt_o  (cnt),
      .sdo_o  (sdo_o)
   );

   dac_rx_decode #(
      .RES   (RES),
      .CNT_W (CNT_W)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .close_i (close_q),
      .cnt_i   (cnt),
      .word_i  (word),
      .vld_o   (cmd_vld_o),
      .op_o    (cmd_op_o),
      .code_o  (cmd_code_o),
      .stb_o   (stb)
   );

   assign stb_write_o  = stb.write;
   assign stb_update_o = stb.update;
   assign stb_wr_upd_o = stb.wr_upd;
   assign stb_pwr_dn_o = stb.pwr_dn;
   assign stb_nop_o    = stb.nop;

   // R6: a command only follows a closed frame
   assert_vld_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |-> $past(close_q));

endmodule

// File: tb/test_dac_serial_rx.sv
`timescale 1ns/1ps
module test_dac_serial_rx;

   localparam int HALF = 5;

   typedef struct packed {
      logic [5:0]  nbits;
      logic [31:0] word;
      logic        vld;
      logic [3:0]  op;
      logic [15:0] code;
   } vec_t;

   // R7 R4 R3 R8 R6 vectors
   localparam vec_t VECS [10] = '{
      '{6'd24, 32'h000FA5C3, 1'b1, 4'h0, 16'hA5C3},   // R7 write, R4 ignored nibble
      '{6'd24, 32'h00100000, 1'b1, 4'h1, 16'h0000},   // R7 update
      '{6'd24, 32'h0030FFFF, 1'b1, 4'h3, 16'hFFFF},   // R7 write+update
      '{6'd24, 32'h00401234, 1'b1, 4'h4, 16'h1234},   // R7 power down
      '{6'd24, 32'h00F08001, 1'b1, 4'hF, 16'h8001},   // R7 no-op
      '{6'd24, 32'h0025AAAA, 1'b0, 4'h0, 16'h0000},   // R8 reserved
      '{6'd32, 32'hA7398000, 1'b1, 4'h3, 16'h8000},   // R3 32-bit padding
      '{6'd23, 32'h00001234, 1'b0, 4'h0, 16'h0000},   // R6 short
      '{6'd24, 32'h00E05555, 1'b0, 4'h0, 16'h0000},   // R8 reserved
      '{6'd32, 32'h001F0001, 1'b1, 4'h1, 16'h0001}    // R3 32-bit update
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic        cs_n = 1'b1;
   logic        sdo, vld, s_wr, s_up, s_wu, s_pd, s_nop;
   logic [3:0]  op;
   logic [15:0] code;
   logic        sdo12, vld12, w0, w1, w2, w3, w4;
   logic [3:0]  op12;
   logic [11:0] code12;

   int nchk = 0, nerr = 0, nvld = 0, nwide = 0, nvld12 = 0;
   logic [3:0]  cap_op;
   logic [15:0] cap_code;
   logic [11:0] cap_code12;
   logic [4:0]  cap_stb;
   logic        prev_vld = 1'b0;
   bit          done = 0;

   always #4 clk = ~clk;

   dac_serial_rx #(.RES(16)) i_dac_serial_rx (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csld_n_i(cs_n),
      .sdo_o(sdo), .cmd_vld_o(vld), .cmd_op_o(op), .cmd_code_o(code),
      .stb_write_o(s_wr), .stb_update_o(s_up), .stb_wr_upd_o(s_wu),
      .stb_pwr_dn_o(s_pd), .stb_nop_o(s_nop));

   dac_serial_rx #(.RES(12)) i_dac_serial_rx_res12 (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csld_n_i(cs_n),
      .sdo_o(sdo12), .cmd_vld_o(vld12), .cmd_op_o(op12), .cmd_code_o(code12),
      .stb_write_o(w0), .stb_update_o(w1), .stb_wr_upd_o(w2),
      .stb_pwr_dn_o(w3), .stb_nop_o(w4));

   always @(negedge clk) begin
      if (vld) begin
         nvld++;
         cap_op   = op;
         cap_code = code;
         cap_stb  = {s_wr, s_up, s_wu, s_pd, s_nop};
         if (prev_vld) nwide++;
      end else if (op != 4'h0 || code != 16'h0) begin
         nwide++;
      end
      if (vld12) begin
         nvld12++;
         cap_code12 = code12;
      end
      prev_vld = vld;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_stb(input logic [3:0] o);
      case (o)
         4'h0:    return 5'b10000;
         4'h1:    return 5'b01000;
         4'h3:    return 5'b00100;
         4'h4:    return 5'b00010;
         4'hF:    return 5'b00001;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input int nbits, input logic [31:0] word, input bit coincide,
                       input bit chk_sdo, input logic [31:0] prev, output int bad);
      bad = 0;
      cs_n = 1'b0;
      wait_n(HALF);
      for (int i = nbits - 1; i >= 0; i--) begin
         int k;
         k = nbits - i;
         sdi = word[i];
         wait_n(HALF);
         if (chk_sdo && k <= 32 && sdo !== prev[32-k]) bad++;
         sck = 1'b1;
         if (coincide && i == 0) cs_n = 1'b1;
         wait_n(HALF);
         sck = 1'b0;
      end
      if (!coincide) begin
         wait_n(HALF);
         cs_n = 1'b1;
      end
      wait_n(20);
   endtask

   task automatic judge(input logic vexp, input logic [3:0] oexp, input logic [15:0] cexp);
      chk("R9 valid pulse count", nvld, {31'd0, vexp});
      chk("R9 pulse width", nwide, 0);
      if (vexp) begin
         chk("R7 command", {28'd0, cap_op}, {28'd0, oexp});
         chk("R7 strobe", {27'd0, cap_stb}, {27'd0, exp_stb(oexp)});
         chk("R4 code16", {16'd0, cap_code}, {16'd0, cexp});
         chk("R4 code12", {20'd0, cap_code12}, {20'd0, cexp[15:4]});
      end
   endtask

   task automatic clr();
      nvld = 0; nwide = 0; nvld12 = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int bad;
      logic [31:0] wa, wb;
      wait_n(4);
      // R1 reset state
      chk("R1 sdo in reset", {31'd0, sdo}, 0);
      chk("R1 valid in reset", {31'd0, vld}, 0);
      rst_n = 1'b1;
      wait_n(6);
      chk("R1 sdo after reset", {31'd0, sdo}, 0);
      chk("R1 no strobes", {27'd0, s_wr, s_up, s_wu, s_pd, s_nop}, 0);
      chk("R1 no valid", nvld, 0);

      for (int v = 0; v < 10; v++) begin
         clr();
         send(int'(VECS[v].nbits), VECS[v].word, 1'b0, 1'b0, 32'd0, bad);
         judge(VECS[v].vld, VECS[v].op, VECS[v].code);
      end

      // R5 chain: frame A then B, B sees A on sdo
      wa = 32'hC3A50F96;
      wb = 32'h8030ABCD;
      clr();
      send(32, wa, 1'b0, 1'b0, 32'd0, bad);
      chk("R8 frame A reserved", nvld, 0);
      clr();
      send(32, wb, 1'b0, 1'b1, wa, bad);
      chk("R5 sdo carries previous word", bad, 0);
      judge(1'b1, 4'h3, 16'hABCD);
      chk("R5 sdo after B", {31'd0, sdo}, {31'd0, wb[31]});

      // R2 clocks with select high are ignored
      clr();
      sdi = 1'b1;
      for (int t = 0; t < 6; t++) begin
         wait_n(HALF); sck = 1'b1; wait_n(HALF); sck = 1'b0;
      end
      wait_n(HALF);
      chk("R2 sdo stable while deselected", {31'd0, sdo}, {31'd0, wb[31]});
      chk("R2 no command while deselected", nvld, 0);
      clr();
      send(24, 32'h00F00000, 1'b0, 1'b1, wb, bad);
      chk("R2 register untouched by idle clocks", bad, 0);
      judge(1'b1, 4'hF, 16'h0000);

      // R10 last rising edge together with select rise
      clr();
      send(24, 32'h00007E81, 1'b1, 1'b0, 32'd0, bad);
      judge(1'b1, 4'h0, 16'h7E81);
      chk("R10 res12 valid", nvld12, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule